// File: doc/BRIEF.md
# Staged Switch-Control Register Bank with I2C Target

This block is the digital control core for three analog 3:1 multiplexers and two general-purpose logic outputs. The block sits on an I2C bus as a target. It oversamples SCL and SDA on a faster system clock, decodes write commands and serves read transactions. Each write carries two data bytes. The first byte names one control element and gives its new on/off value. The second byte carries a load flag and an active-low soft-reset bit.

Writes first land in a shadow register. The live register, which drives the switches and the outputs, takes a copy of the shadow only when a command arrives with its load flag set. A host can therefore stage changes to several switches and apply all of them in the same clock cycle. If the host sets the load flag on every command, each command takes effect as soon as it is received. A read returns the live state in a fixed 16-bit map.

Top module: `triplex_switch_ctrl`

## Requirements
- R1: After power-up reset, all nine switch controls are 0 (open) and both outputs are low, in both the shadow and the live register.
- R2: The target answers only to the 7-bit address {ADDR_FIXED, addr_strap_i}. Any other address is not acknowledged, and the bytes that follow it change nothing.
- R3: Data byte 1 selects the element. Bits [7:6] are the mux (0..2 for mux 1..3, 3 for the outputs). Bits [5:4] are the input (0=A, 1=B, 2=C) or, when the mux field is 3, the output (0=GPO1, 1=GPO2). Bit 0 is the new value. Bits [3:1] are ignored. Data byte 2 holds the load flag in bit 1 and the soft-reset bit in bit 0; bits [7:2] are ignored.
- R4: A command with load=0 and reset bit=1 changes only the shadow register. sw_close_o and gpo_o stay unchanged.
- R5: A command with load=1 and reset bit=1 copies the updated shadow into the live register. Every change staged since the last commit appears on the outputs in the same cycle. Several commands may share one transaction.
- R6: A command with reset bit 0 clears the shadow and the live register, whatever its load flag.
- R7: A read (R/W=1) sends two bytes, MSB first, from the live register. The bit map is: bits 15..13 = mux 1 inputs A, B, C; bits 11..9 = mux 2 inputs A, B, C; bits 7..5 = mux 3 inputs A, B, C; bit 3 = GPO1; bit 2 = GPO2. Bits 12, 8, 4, 1 and 0 read 0. A 1 means closed or high.
- R8: The target pulls SDA low to acknowledge a matching address byte and every write data byte.
- R9: A START that arrives in the middle of a transaction aborts it. A half-received command is discarded and nothing is committed.
- R10: A selector that names no element (input field 3, or output index 2 or 3) leaves the shadow unchanged. Its load flag still commits the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Active-low power-up reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| addr_strap_i | input | 3 | Low bits of the target address, from straps |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain drive) |
| sw_close_o | output | 9 | Live switch controls, index mux*3+input, 1 = closed |
| gpo_o | output | 2 | Live general-purpose outputs, bit 0 = GPO1 |

## Verification
The live outputs change four system clocks after the SCL rising edge that carries the last bit of a committing byte: two synchronizer stages, one protocol register and one bank register. The target changes SDA three clocks after an SCL falling edge. The bench holds each SCL phase for six clocks, so SDA is sampled well after the target has driven it. The reference model is updated only once a STOP has settled. The bench compares the outputs with the model on every clock in the quiet windows between write transactions, and compares read data bit by bit against a map built from the model.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;
   localparam int NUM_MUX = 3;
   localparam int NUM_IN  = 3;
   localparam int NUM_GPO = 2;
   localparam int NUM_SW  = NUM_MUX * NUM_IN;
   localparam int NUM_CTL = NUM_SW + NUM_GPO;
   localparam int RB_W    = 16;

   typedef logic [NUM_CTL-1:0] ctl_vec_t;

   typedef enum logic [3:0] {
      S_IDLE, S_ADDR, S_AACK_WAIT, S_AACK, S_WR,
      S_WACK_WAIT, S_WACK, S_RD, S_RACK
   } tgt_state_e;

   // Lay the live vector into the 16-bit status word; pad positions stay 0.
   function automatic logic [RB_W-1:0] status_word(input ctl_vec_t v);
      logic [RB_W-1:0] w;
      w = '0;
      for (int m = 0; m < NUM_MUX; m++)
         for (int i = 0; i < NUM_IN; i++)
            w[RB_W-1-4*m-i] = v[NUM_IN*m+i];
      w[3] = v[NUM_SW];
      w[2] = v[NUM_SW+1];
      return w;
   endfunction
endpackage

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("sw_line_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_d, sda_d;
   logic scl_s, sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
         scl_d    <= scl_s;
         sda_d    <= sda_s;
      end
   end

   assign scl_s      = scl_pipe[SYNC_STAGES-1];
   assign sda_s      = sda_pipe[SYNC_STAGES-1];
   assign sda_s_o    = sda_s;
   assign scl_rise_o = scl_s & ~scl_d;
   assign scl_fall_o = ~scl_s & scl_d;
   assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/sw_i2c_target.sv
module sw_i2c_target
   import sw_ctrl_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int STRAP_W = 3,
   parameter logic [ADDR_W-STRAP_W-1:0] ADDR_FIXED = 4'b1001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s_i,
   input  logic               scl_rise_i,
   input  logic               scl_fall_i,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic [RB_W-1:0]    status_i,
   output logic               sda_oe_o,
   output logic               cmd_valid_o,
   output logic [1:0]         cmd_mux_o,
   output logic [1:0]         cmd_in_o,
   output logic               cmd_val_o,
   output logic               cmd_load_o,
   output logic               cmd_nrst_o
);
   if (ADDR_W != 7) begin : g_bad_addr
      $error("sw_i2c_target: ADDR_W must be 7");
   end
   if (STRAP_W >= ADDR_W) begin : g_bad_strap
      $error("sw_i2c_target: STRAP_W must be below ADDR_W");
   end

   tgt_state_e        state_q;
   logic [3:0]        bitcnt_q;
   logic [ADDR_W-1:0] rxsr_q;
   logic [RB_W-2:0]   txsr_q;
   logic              is_rd_q, phase_q, rd_second_q, oe_q, cmd_v_q;
   logic [4:0]        sel_q;
   logic [1:0]        ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         bitcnt_q    <= '0;
         rxsr_q      <= '0;
         txsr_q      <= '0;
         is_rd_q     <= 1'b0;
         phase_q     <= 1'b0;
         rd_second_q <= 1'b0;
         oe_q        <= 1'b0;
         cmd_v_q     <= 1'b0;
         sel_q       <= '0;
         ctl_q       <= '0;
      end else begin
         cmd_v_q <= 1'b0;
         if (start_i) begin
            state_q  <= S_ADDR;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
            phase_q  <= 1'b0;
         end else if (stop_i) begin
            state_q <= S_IDLE;
            oe_q    <= 1'b0;
         end else begin
            unique case (state_q)
               S_ADDR: if (scl_rise_i) begin
                  rxsr_q <= {rxsr_q[ADDR_W-2:0], sda_s_i};
                  if (bitcnt_q == 4'd7) begin
                     bitcnt_q <= '0;
                     if (rxsr_q == {ADDR_FIXED, strap_i}) begin
                        is_rd_q <= sda_s_i;
                        state_q <= S_AACK_WAIT;
                     end else begin
                        state_q <= S_IDLE;
                     end
                  end else begin
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end
               end
               S_AACK_WAIT: if (scl_fall_i) begin
                  oe_q    <= 1'b1;
                  state_q <= S_AACK;
               end
               S_AACK: if (scl_fall_i) begin
                  bitcnt_q <= '0;
                  if (is_rd_q) begin
                     txsr_q      <= status_i[RB_W-2:0];
                     oe_q        <= ~status_i[RB_W-1];
                     rd_second_q <= 1'b0;
                     state_q     <= S_RD;
                  end else begin
                     oe_q    <= 1'b0;
                     state_q <= S_WR;
                  end
               end
               S_WR: if (scl_rise_i) begin
                  rxsr_q <= {rxsr_q[ADDR_W-2:0], sda_s_i};
                  if (bitcnt_q == 4'd7) begin
                     bitcnt_q <= '0;
                     state_q  <= S_WACK_WAIT;
                     if (!phase_q) begin
                        sel_q   <= {rxsr_q[6:3], sda_s_i};
                        phase_q <= 1'b1;
                     end else begin
                        ctl_q   <= {rxsr_q[0], sda_s_i};
                        cmd_v_q <= 1'b1;
                        phase_q <= 1'b0;
                     end
                  end else begin
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end
               end
               S_WACK_WAIT: if (scl_fall_i) begin
                  oe_q    <= 1'b1;
                  state_q <= S_WACK;
               end
               S_WACK: if (scl_fall_i) begin
                  oe_q    <= 1'b0;
                  state_q <= S_WR;
               end
               S_RD: begin
                  if (scl_rise_i) begin
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end else if (scl_fall_i) begin
                     if (bitcnt_q == 4'd8) begin
                        oe_q     <= 1'b0;
                        bitcnt_q <= '0;
                        state_q  <= S_RACK;
                     end else begin
                        txsr_q <= {txsr_q[RB_W-3:0], 1'b0};
                        oe_q   <= ~txsr_q[RB_W-2];
                     end
                  end
               end
               S_RACK: begin
                  if (scl_rise_i && sda_s_i) begin
                     state_q <= S_IDLE;
                  end else if (scl_fall_i) begin
                     state_q <= S_RD;
                     if (!rd_second_q) begin
                        txsr_q      <= {txsr_q[RB_W-3:0], 1'b0};
                        oe_q        <= ~txsr_q[RB_W-2];
                        rd_second_q <= 1'b1;
                     end else begin
                        txsr_q      <= status_i[RB_W-2:0];
                        oe_q        <= ~status_i[RB_W-1];
                        rd_second_q <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o    = oe_q;
   assign cmd_valid_o = cmd_v_q;
   assign cmd_mux_o   = sel_q[4:3];
   assign cmd_in_o    = sel_q[2:1];
   assign cmd_val_o   = sel_q[0];
   assign cmd_load_o  = ctl_q[1];
   assign cmd_nrst_o  = ctl_q[0];

   assert_start_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (state_q == S_ADDR) && !cmd_v_q);
   assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE) |-> !oe_q);
   assert_cmd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_v_q |=> !cmd_v_q);
endmodule

// File: rtl/sw_bank.sv
module sw_bank
   import sw_ctrl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid_i,
   input  logic [1:0] cmd_mux_i,
   input  logic [1:0] cmd_in_i,
   input  logic       cmd_val_i,
   input  logic       cmd_load_i,
   input  logic       cmd_nrst_i,
   output ctl_vec_t   live_o
);
   ctl_vec_t shadow_q, live_q, hit, upd;

   for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
      if (k < NUM_SW) begin : g_sw
         assign hit[k] = (cmd_mux_i == 2'(k / NUM_IN)) && (cmd_in_i == 2'(k % NUM_IN));
      end else begin : g_gpo
         assign hit[k] = (cmd_mux_i == 2'(NUM_MUX)) && (cmd_in_i == 2'(k - NUM_SW));
      end
      assign upd[k] = hit[k] ? cmd_val_i : shadow_q[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         live_q   <= '0;
      end else if (cmd_valid_i) begin
         if (!cmd_nrst_i) begin
            shadow_q <= '0;
            live_q   <= '0;
         end else begin
            shadow_q <= upd;
            if (cmd_load_i) live_q <= upd;
         end
      end
   end

   assign live_o = live_q;

   assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
   assert_stage_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_i && cmd_nrst_i && !cmd_load_i |=> $stable(live_q));
   assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid_i |=> $stable(live_q) && $stable(shadow_q));
   assert_commit_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_i && cmd_nrst_i && cmd_load_i |=> live_q == shadow_q);
   assert_soft_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_i && !cmd_nrst_i |=> live_q == '0 && shadow_q == '0);
endmodule

// File: rtl/triplex_switch_ctrl.sv
module triplex_switch_ctrl
   import sw_ctrl_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 7,
   parameter int STRAP_W     = 3,
   parameter logic [ADDR_W-STRAP_W-1:0] ADDR_FIXED = 4'b1001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] addr_strap_i,
   output logic               sda_oe_o,
   output logic [NUM_SW-1:0]  sw_close_o,
   output logic [NUM_GPO-1:0] gpo_o
);
   logic sda_s, scl_rise, scl_fall, start, stop;
   logic cmd_valid, cmd_val, cmd_load, cmd_nrst;
   logic [1:0] cmd_mux, cmd_in;
   ctl_vec_t live;
   logic [RB_W-1:0] status;

   sw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start), .stop_o(stop)
   );

   sw_i2c_target #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W), .ADDR_FIXED(ADDR_FIXED)) u_tgt (
      .clk(clk), .rst_n(rst_n), .sda_s_i(sda_s), .scl_rise_i(scl_rise),
      .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
      .strap_i(addr_strap_i), .status_i(status), .sda_oe_o(sda_oe_o),
      .cmd_valid_o(cmd_valid), .cmd_mux_o(cmd_mux), .cmd_in_o(cmd_in),
      .cmd_val_o(cmd_val), .cmd_load_o(cmd_load), .cmd_nrst_o(cmd_nrst)
   );

   sw_bank u_bank (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_mux_i(cmd_mux),
      .cmd_in_i(cmd_in), .cmd_val_i(cmd_val), .cmd_load_i(cmd_load),
      .cmd_nrst_i(cmd_nrst), .live_o(live)
   );

   assign status     = status_word(live);
   assign sw_close_o = live[NUM_SW-1:0];
   assign gpo_o      = live[NUM_CTL-1:NUM_SW];
endmodule

// File: tb/triplex_switch_ctrl_bench.sv
module triplex_switch_ctrl_bench;
   localparam int Q = 6;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_drv = 1'b1, sda_drv = 1'b1;
   logic [2:0] strap = 3'b010;
   logic sda_oe;
   logic [8:0] sw_close;
   logic [1:0] gpo;
   wire sda_line = sda_drv & ~sda_oe;

   int n_chk = 0, n_fail = 0;
   bit quiet = 1'b0;
   logic [10:0] exp_sh = '0, exp_live = '0;

   triplex_switch_ctrl u_triplex_switch_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
      .addr_strap_i(strap), .sda_oe_o(sda_oe), .sw_close_o(sw_close), .gpo_o(gpo)
   );

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk)
      if (quiet && rst_n)
         chk({gpo, sw_close} === exp_live, "R1 R4 R5 live outputs vs model",
             {5'b0, gpo, sw_close}, {5'b0, exp_live});

   task automatic wq(); repeat (Q) @(negedge clk); endtask
   task automatic bit_w(input logic b);
      sda_drv = b; wq(); scl_drv = 1'b1; wq(); wq(); scl_drv = 1'b0; wq();
   endtask
   task automatic bit_r(output logic b);
      sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); b = sda_line; wq(); scl_drv = 1'b0; wq();
   endtask
   task automatic i2c_start();
      sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b0; wq(); scl_drv = 1'b0; wq();
   endtask
   task automatic i2c_stop();
      sda_drv = 1'b0; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b1; wq();
   endtask
   task automatic wr_byte(input logic [7:0] d, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) bit_w(d[i]);
      bit_r(a);
      ack = ~a;
   endtask

   function automatic logic [7:0] mk(input int m, input int i, input bit v);
      return {2'(m), 2'(i), 3'b000, v};
   endfunction

   // Model: element index mux*3+input; outputs at 9 and 10.
   task automatic model_cmd(input logic [7:0] b1, input logic [7:0] b2);
      int m = int'(b1[7:6]);
      int i = int'(b1[5:4]);
      if (!b2[0]) begin
         exp_sh = '0; exp_live = '0;
      end else begin
         if (m < 3 && i < 3) exp_sh[m*3+i] = b1[0];
         else if (m == 3 && i < 2) exp_sh[9+i] = b1[0];
         if (b2[1]) exp_live = exp_sh;
      end
   endtask

   task automatic settle(); repeat (8) @(negedge clk); endtask

   task automatic do_write(input logic [6:0] a, input int n, input logic [7:0] d [4],
                           input bit exp_ack, input string tag);
      logic ack;
      quiet = 1'b0;
      i2c_start();
      wr_byte({a, 1'b0}, ack);
      chk(ack == exp_ack, {"R8 R2 address ack ", tag}, 16'(ack), 16'(exp_ack));
      for (int k = 0; k < n; k++) begin
         wr_byte(d[k], ack);
         chk(ack == exp_ack, {"R8 data ack ", tag}, 16'(ack), 16'(exp_ack));
      end
      i2c_stop();
      settle();
      if (exp_ack)
         for (int k = 0; k + 1 < n; k += 2) model_cmd(d[k], d[k+1]);
      quiet = 1'b1;
   endtask

   task automatic do_read(input logic [6:0] a, input string tag);
      logic ack, b;
      logic [15:0] got, exp;
      i2c_start();
      wr_byte({a, 1'b1}, ack);
      chk(ack, {"R8 read address ack ", tag}, 16'(ack), 16'd1);
      for (int k = 15; k >= 0; k--) begin
         bit_r(b);
         got[k] = b;
         if (k == 8) bit_w(1'b0);
      end
      bit_w(1'b1);
      i2c_stop();
      exp = '0;
      for (int m = 0; m < 3; m++)
         for (int i = 0; i < 3; i++) exp[15-4*m-i] = exp_live[m*3+i];
      exp[3] = exp_live[9];
      exp[2] = exp_live[10];
      chk(got === exp, {"R7 readback ", tag}, got, exp);
      settle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d [4];
      logic [6:0] adr;
      logic ack;
      adr = {4'b1001, 3'b010};
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      quiet = 1'b1;
      repeat (3) @(negedge clk);
      chk({gpo, sw_close} == '0 && !sda_oe, "R1 reset state", {5'b0, gpo, sw_close}, 16'h0);
      do_read(adr, "R1 after reset");

      d = '{mk(0, 0, 1), 8'h03, 8'h00, 8'h00};
      do_write(adr, 2, d, 1'b1, "R5 single commit");
      chk(sw_close == 9'h001, "R5 mux1 A closed", {7'b0, sw_close}, 16'h001);

      d = '{mk(1, 1, 1), 8'h01, 8'h00, 8'h00};
      do_write(adr, 2, d, 1'b1, "R4 stage mux2 B");
      d = '{mk(3, 1, 1), 8'h01, 8'h00, 8'h00};
      do_write(adr, 2, d, 1'b1, "R4 stage GPO2");
      chk({gpo, sw_close} == 11'h001, "R4 live unchanged", {5'b0, gpo, sw_close}, 16'h001);
      do_read(adr, "R7 live not shadow");

      d = '{mk(2, 2, 1), 8'h03, 8'h00, 8'h00};
      do_write(adr, 2, d, 1'b1, "R5 commit all staged");
      chk({gpo, sw_close} == 11'h511, "R5 three changes together", {5'b0, gpo, sw_close}, 16'h511);
      do_read(adr, "R7 map after commit");

      d = '{mk(3, 2, 1), 8'h03, mk(0, 3, 1), 8'h03};
      do_write(adr, 4, d, 1'b1, "R10 bad selectors");
      chk({gpo, sw_close} == 11'h511, "R10 no element changed", {5'b0, gpo, sw_close}, 16'h511);

      d = '{mk(0, 1, 1), 8'h03, 8'h00, 8'h00};
      do_write({4'b1001, 3'b011}, 2, d, 1'b0, "R2 wrong address");
      chk({gpo, sw_close} == 11'h511, "R2 ignored after nack", {5'b0, gpo, sw_close}, 16'h511);

      strap = 3'b101;
      adr = {4'b1001, 3'b101};
      d = '{mk(0, 0, 0), 8'h03, 8'h00, 8'h00};
      do_write(adr, 2, d, 1'b1, "R2 new strap");
      chk(sw_close[0] == 1'b0, "R2 strap address accepted", {15'b0, sw_close[0]}, 16'h0);

      d = '{{2'd1, 2'd0, 3'b111, 1'b1}, 8'hFF, 8'h00, 8'h00};
      do_write(adr, 2, d, 1'b1, "R3 ignored bits");
      chk(sw_close[3] == 1'b1, "R3 mux2 A closed", {15'b0, sw_close[3]}, 16'h1);

      quiet = 1'b0;
      i2c_start();
      wr_byte({adr, 1'b0}, ack);
      wr_byte(mk(1, 2, 1), ack);
      i2c_start();
      wr_byte({adr, 1'b0}, ack);
      wr_byte(mk(0, 3, 0), ack);
      wr_byte(8'h03, ack);
      i2c_stop();
      settle();
      quiet = 1'b1;
      chk(sw_close[5] == 1'b0, "R9 aborted command discarded", {15'b0, sw_close[5]}, 16'h0);

      d = '{mk(2, 0, 1), 8'h01, mk(3, 0, 1), 8'h03};
      do_write(adr, 4, d, 1'b1, "R5 two in one transfer");
      chk(gpo[0] && sw_close[6], "R5 both applied", {14'b0, gpo[0], sw_close[6]}, 16'h3);
      do_read(adr, "R7 with GPO1");

      d = '{mk(0, 2, 1), 8'h00, 8'h00, 8'h00};
      do_write(adr, 2, d, 1'b1, "R6 soft reset");
      chk({gpo, sw_close} == '0, "R6 all cleared", {5'b0, gpo, sw_close}, 16'h0);
      d = '{mk(0, 1, 1), 8'h03, 8'h00, 8'h00};
      do_write(adr, 2, d, 1'b1, "R6 shadow cleared too");
      chk({gpo, sw_close} == 11'h002, "R6 only new element", {5'b0, gpo, sw_close}, 16'h002);
      do_read(adr, "R7 final");

      quiet = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule